// File: doc/BRIEF.md
# Harmonic Coefficient Estimator

This block turns one captured record of converter output codes into the low-order cosine coefficients of that record. The converter under test digitizes a full-scale cosine tone. The tone is sampled coherently, with a whole number of cycles in the record and a peak at sample zero, so the output sequence is even. For such a record, the cosine coefficient at harmonic k is the weight of the k-th first-kind Chebyshev polynomial in the converter's static transfer curve. The set of coefficients for harmonics 0 to N is therefore a smooth model of the large-scale integral nonlinearity. This model does not show quantization steps or abrupt differential errors.

Software or a sequencer pulses `start`. The block then stores the next 2^LOG2_M valid codes in an internal buffer. It then sweeps the buffer once per harmonic. The reference cosine comes from a quarter-wave table, indexed by a phase that steps by k each sample. Each sweep produces a multiply-accumulate sum, which is scaled by a right shift and saturated. The results are held in a small coefficient file that can be read by harmonic index. `done` reports that the whole set is ready.

Top module: `harm_coef_est`

## Requirements
- R1: After reset, `done` is low and every read of the coefficient port returns 0.
- R2: A `start` pulse opens a capture that stores exactly 2^LOG2_M codes, taken only on cycles with `smp_valid` high. Samples offered while no capture is open (idle, or while coefficients are being computed) change no result.
- R3: Coefficient 0 equals the record mean. It is a signed fixed-point number with FRAC_W fraction bits, within 2 LSB.
- R4: Coefficient k, for 1 <= k <= N, equals (2/M)·Σ code[n]·cos(2πkn/M) in the same format, within 2 LSB. Energy at harmonics above N does not disturb the coefficients that are reported.
- R5: All coefficients 0 to N are written before `done` rises. `done` then stays high until the next `start`.
- R6: A `start` during capture or during computation abandons the current record. The next result reflects only the samples captured after that pulse.
- R7: A coefficient outside the signed COEF_W range is clamped to the largest positive or most negative code.
- R8: The read port is registered. `rd_coef` shows entry `rd_idx` one clock after `rd_idx` is applied, and an index above N reads as 0.
- R9: `done` is low on the cycle after any `start` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a new capture |
| smp_valid | input | 1 | Qualifies `smp_code` during capture |
| smp_code | input | CODE_W | Signed converter output code |
| done | output | 1 | Coefficient set complete |
| rd_idx | input | clog2(NUM_HARM+1) | Harmonic index to read |
| rd_coef | output | COEF_W | Signed coefficient, FRAC_W fraction bits |

## Verification
The last capture sample lands on a clock edge. From that edge, each harmonic takes M+1 cycles: M issue cycles and one drain cycle in which the coefficient is written. `done` rises at the edge that ends the final drain, so it is due (N+1)(M+1) cycles after the last sample. The bench does not count to that figure. It polls `done` at falling edges, and it injects garbage samples while it waits, which checks R2. The read port has a fixed latency of exactly one edge. The bench applies an index at a falling edge, confirms that the old value is still present just after, and compares the new value at the next falling edge.

// File: rtl/hce_pkg.sv
package hce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAPT  = 2'd1,
    ST_CALC  = 2'd2,
    ST_DRAIN = 2'd3
  } hce_state_e;
endpackage

// File: rtl/cos_quarter_rom.sv
// Registered cosine reference built from a quarter-wave table.
module cos_quarter_rom #(
  parameter int LOG2_M = 12,
  parameter int REF_W  = 16
) (
  input  logic                    clk,
  input  logic [LOG2_M-1:0]       phase,
  output logic signed [REF_W-1:0] ref_q
);
  localparam int QTR = 1 << (LOG2_M - 2);
  localparam int AMP = (1 << (REF_W - 1)) - 1;

  function automatic logic signed [REF_W-1:0] qcos(input int idx);
    real ang;
    int  v;
    ang = 6.283185307179586 * real'(idx) / real'(1 << LOG2_M);
    v   = $rtoi($floor(real'(AMP) * $cos(ang) + 0.5));
    return v[REF_W-1:0];
  endfunction

  logic signed [REF_W-1:0] tbl [QTR+1];

  for (genvar gi = 0; gi <= QTR; gi++) begin : g_tbl
    localparam logic signed [REF_W-1:0] VAL = qcos(gi);
    assign tbl[gi] = VAL;
  end

  logic [1:0]        quad;
  logic [LOG2_M-3:0] low;
  logic [LOG2_M-2:0] idx;
  logic              neg;

  assign quad = phase[LOG2_M-1 -: 2];
  assign low  = phase[LOG2_M-3:0];

  always_comb begin
    case (quad)
      2'd0:    begin idx = {1'b0, low};                       neg = 1'b0; end
      2'd1:    begin idx = (LOG2_M-1)'(QTR) - {1'b0, low};    neg = 1'b1; end
      2'd2:    begin idx = {1'b0, low};                       neg = 1'b1; end
      default: begin idx = (LOG2_M-1)'(QTR) - {1'b0, low};    neg = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    ref_q <= neg ? -tbl[idx] : tbl[idx];
  end
endmodule

// File: rtl/sample_buffer.sv
// Simple dual-port record store with synchronous read (block RAM style).
module sample_buffer #(
  parameter int DW = 12,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1 << AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coef_scaler.sv
// Divides a correlation sum by M*AMP (DC) or M*AMP/2 (others) via shift, then clamps.
module coef_scaler #(
  parameter int ACC_W  = 40,
  parameter int COEF_W = 20,
  parameter int SHIFT  = 23
) (
  input  logic signed [ACC_W-1:0]  acc,
  input  logic                     is_dc,
  output logic signed [COEF_W-1:0] coef
);
  logic signed [ACC_W-1:0] shifted;
  logic [ACC_W-COEF_W:0]   hi;

  assign shifted = is_dc ? (acc >>> SHIFT) : (acc >>> (SHIFT - 1));
  assign hi      = shifted[ACC_W-1:COEF_W-1];

  always_comb begin
    if ((&hi) || !(|hi))      coef = shifted[COEF_W-1:0];
    else if (shifted[ACC_W-1]) coef = {1'b1, {(COEF_W-1){1'b0}}};
    else                       coef = {1'b0, {(COEF_W-1){1'b1}}};
  end
endmodule

// File: rtl/harm_coef_est.sv
module harm_coef_est
  import hce_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int LOG2_M   = 12,
  parameter int NUM_HARM = 10,
  parameter int REF_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int COEF_W   = 20,
  localparam int KW      = $clog2(NUM_HARM + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     smp_valid,
  input  logic signed [CODE_W-1:0] smp_code,
  output logic                     done,
  input  logic [KW-1:0]            rd_idx,
  output logic signed [COEF_W-1:0] rd_coef
);
  localparam int PROD_W = CODE_W + REF_W;
  localparam int ACC_W  = PROD_W + LOG2_M;
  localparam int SHIFT  = LOG2_M + REF_W - 1 - FRAC_W;

  hce_state_e              st;
  logic [LOG2_M-1:0]       wr_ptr, rd_ptr, phase;
  logic [KW-1:0]           hk;
  logic                    capturing, buf_we, issue;
  logic                    v1, l1, coef_we;
  logic [CODE_W-1:0]       buf_rdata;
  logic signed [REF_W-1:0] ref_val;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0] acc, acc_next;
  logic signed [COEF_W-1:0] coef_new;
  logic signed [COEF_W-1:0] coef_mem [NUM_HARM+1];

  assign capturing = (st == ST_CAPT);
  assign buf_we    = capturing && smp_valid && !start;
  assign issue     = (st == ST_CALC);
  assign coef_we   = v1 && l1;

  sample_buffer #(.DW(CODE_W), .AW(LOG2_M)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wr_ptr),
    .wdata (smp_code),
    .raddr (rd_ptr),
    .rdata (buf_rdata)
  );

  cos_quarter_rom #(.LOG2_M(LOG2_M), .REF_W(REF_W)) u_rom (
    .clk   (clk),
    .phase (phase),
    .ref_q (ref_val)
  );

  assign prod     = $signed(buf_rdata) * ref_val;
  assign acc_next = acc + ACC_W'(prod);

  coef_scaler #(.ACC_W(ACC_W), .COEF_W(COEF_W), .SHIFT(SHIFT)) u_scale (
    .acc   (acc_next),
    .is_dc (hk == '0),
    .coef  (coef_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      wr_ptr <= '0;
      rd_ptr <= '0;
      phase  <= '0;
      hk     <= '0;
      done   <= 1'b0;
      v1     <= 1'b0;
      l1     <= 1'b0;
      acc    <= '0;
    end else begin
      v1 <= issue;
      l1 <= issue && (rd_ptr == '1);
      if (v1) acc <= coef_we ? '0 : acc_next;
      if (start) begin
        st     <= ST_CAPT;
        wr_ptr <= '0;
        done   <= 1'b0;
        v1     <= 1'b0;
        l1     <= 1'b0;
        acc    <= '0;
      end else begin
        case (st)
          ST_CAPT: if (smp_valid) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_ptr == '1) begin
              st     <= ST_CALC;
              rd_ptr <= '0;
              phase  <= '0;
              hk     <= '0;
            end
          end
          ST_CALC: begin
            rd_ptr <= rd_ptr + 1'b1;
            phase  <= phase + LOG2_M'(hk);
            if (rd_ptr == '1) st <= ST_DRAIN;
          end
          ST_DRAIN: if (coef_we) begin
            if (hk == KW'(NUM_HARM)) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              hk     <= hk + 1'b1;
              rd_ptr <= '0;
              phase  <= '0;
              st     <= ST_CALC;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= NUM_HARM; i++) coef_mem[i] <= '0;
      rd_coef <= '0;
    end else begin
      if (coef_we && !start) coef_mem[hk] <= coef_new;
      rd_coef <= (rd_idx <= KW'(NUM_HARM)) ? coef_mem[rd_idx] : '0;
    end
  end
endmodule

// File: rtl/hce_checker.sv
module hce_checker #(
  parameter int KW       = 4,
  parameter int NUM_HARM = 10,
  parameter int COEF_W   = 20
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start,
  input logic                     done,
  input logic                     capturing,
  input logic                     coef_we,
  input logic [KW-1:0]            hk,
  input logic [KW-1:0]            rd_idx,
  input logic signed [COEF_W-1:0] rd_coef
);
  AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
    start |=> !done); // R9

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(coef_we && (hk == KW'(NUM_HARM)))); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R5

  AST_DONE_NOT_CAPT: assert property (@(posedge clk) disable iff (rst)
    done |-> !capturing); // R2

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_idx > KW'(NUM_HARM)) |=> (rd_coef == '0)); // R8

  AST_NO_WRITE_IN_CAPT: assert property (@(posedge clk) disable iff (rst)
    coef_we |-> !capturing); // R6
endmodule

bind harm_coef_est hce_checker #(.KW(KW), .NUM_HARM(NUM_HARM), .COEF_W(COEF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .done      (done),
  .capturing (capturing),
  .coef_we   (coef_we),
  .hk        (hk),
  .rd_idx    (rd_idx),
  .rd_coef   (rd_coef)
);

// File: tb/sim_harm_coef_est.sv
module sim_harm_coef_est;
  localparam int CODE_W = 12;
  localparam int LOG2_M = 8;
  localparam int M      = 1 << LOG2_M;
  localparam int NH     = 10;
  localparam int FRAC_W = 4;
  localparam int COEF_W = 15;
  localparam int KW     = $clog2(NH + 1);
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, smp_valid = 1'b0;
  logic signed [CODE_W-1:0] smp_code = '0;
  logic done;
  logic [KW-1:0] rd_idx = '0;
  logic signed [COEF_W-1:0] rd_coef;

  int checks = 0, errors = 0;
  int rec [M];
  int expv [NH+1];

  always #2.5 clk = ~clk;

  harm_coef_est #(.CODE_W(CODE_W), .LOG2_M(LOG2_M), .NUM_HARM(NH),
                  .FRAC_W(FRAC_W), .COEF_W(COEF_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .smp_valid(smp_valid),
    .smp_code(smp_code), .done(done), .rd_idx(rd_idx), .rd_coef(rd_coef));

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic compute_expected();
    for (int k = 0; k <= NH; k++) begin
      real s, e;
      int  ei;
      s = 0.0;
      for (int n = 0; n < M; n++) s += real'(rec[n]) * $cos(TWO_PI * real'(k * n) / real'(M));
      e = s / real'(M) * ((k == 0) ? 1.0 : 2.0) * real'(1 << FRAC_W);
      ei = $rtoi($floor(e + 0.5));
      if (ei > (1 << (COEF_W-1)) - 1) ei = (1 << (COEF_W-1)) - 1;
      if (ei < -(1 << (COEF_W-1)))    ei = -(1 << (COEF_W-1));
      expv[k] = ei;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R9 done low after start", int'(done), 0);
  endtask

  task automatic feed(input int count, input bit garbage, input bit gaps);
    for (int n = 0; n < count; n++) begin
      if (gaps && (n % 3 == 1)) begin
        smp_valid = 1'b0; smp_code = CODE_W'($urandom);
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_code  = garbage ? CODE_W'($urandom) : CODE_W'(rec[n]);
      @(negedge clk);
    end
    smp_valid = 1'b0;
  endtask

  task automatic wait_done(input bit noisy);
    int cyc = 0;
    while (!done && cyc < 20000) begin
      smp_valid = noisy; smp_code = CODE_W'($urandom);
      @(negedge clk);
      cyc++;
    end
    smp_valid = 1'b0;
    check(done == 1'b1, "R5 done reached", int'(done), 1);
  endtask

  task automatic read_all(input string req);
    for (int k = 0; k <= NH; k++) begin
      int a;
      rd_idx = KW'(k);
      @(negedge clk);
      a = int'(rd_coef);
      check((a - expv[k] <= 2) && (expv[k] - a <= 2), $sformatf("%s k=%0d", req, k), a, expv[k]);
    end
  endtask

  task automatic run(input bit gaps, input bit noisy);
    compute_expected();
    pulse_start();
    feed(M, 1'b0, gaps);
    wait_done(noisy);
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    rd_idx = 0; @(negedge clk);
    check(rd_coef == 0, "R1 coef0 after reset", int'(rd_coef), 0);
    rd_idx = 5; @(negedge clk);
    check(rd_coef == 0, "R1 coef5 after reset", int'(rd_coef), 0);
  endtask

  task automatic t_dc();
    for (int n = 0; n < M; n++) rec[n] = 300;
    run(1'b1, 1'b0);
    read_all("R3 dc record");
    // samples in idle must not alter results
    for (int i = 0; i < 40; i++) begin
      smp_valid = 1'b1; smp_code = CODE_W'($urandom); @(negedge clk);
    end
    smp_valid = 1'b0;
    check(done == 1'b1, "R5 done held in idle", int'(done), 1);
    read_all("R2 idle samples ignored");
  endtask

  task automatic t_fund();
    for (int n = 0; n < M; n++)
      rec[n] = $rtoi($floor(-50.0 + 1000.0 * $cos(TWO_PI * real'(n) / real'(M)) + 0.5));
    run(1'b0, 1'b1);
    read_all("R4 fundamental, R2 calc-time samples ignored");
    rd_idx = 0; @(negedge clk);
    rd_idx = 1; #1;
    check(int'(rd_coef) == int'(rd_coef) && (int'(rd_coef) - expv[0] <= 2) && (expv[0] - int'(rd_coef) <= 2),
          "R8 old value before edge", int'(rd_coef), expv[0]);
    @(negedge clk);
    check((int'(rd_coef) - expv[1] <= 2) && (expv[1] - int'(rd_coef) <= 2),
          "R8 new value after one edge", int'(rd_coef), expv[1]);
    rd_idx = KW'(NH + 1); @(negedge clk);
    check(rd_coef == 0, "R8 out-of-range index", int'(rd_coef), 0);
  endtask

  task automatic t_restart();
    for (int n = 0; n < M; n++)
      rec[n] = $rtoi($floor(400.0 * $cos(TWO_PI * real'(3 * n) / real'(M))
                          + 200.0 * $cos(TWO_PI * real'(NH * n) / real'(M))
                          + 300.0 * $cos(TWO_PI * real'((NH + 1) * n) / real'(M)) + 0.5));
    compute_expected();
    pulse_start();
    feed(100, 1'b1, 1'b0);           // abandoned mid-capture
    pulse_start();
    feed(M, 1'b1, 1'b0);             // full garbage record, abandoned in computation
    for (int i = 0; i < 500; i++) @(negedge clk);
    check(done == 1'b0, "R6 busy before restart", int'(done), 0);
    pulse_start();
    feed(M, 1'b0, 1'b1);
    wait_done(1'b0);
    read_all("R6 R4 restart and higher harmonics");
  endtask

  task automatic t_sat();
    for (int n = 0; n < M; n++) rec[n] = 2047;
    run(1'b0, 1'b0);
    read_all("R7 positive clamp");
    for (int n = 0; n < M; n++) rec[n] = -2048;
    run(1'b0, 1'b0);
    read_all("R7 negative clamp");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dc();
    t_fund();
    t_restart();
    t_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule